// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This block is the digital decision core of a hot-pluggable two-wire (I2C/SMBus) bus buffer. The buffer sits between a live backplane segment and a card segment. The block receives sampled logic levels of the backplane and card SDA/SCL lines, an enable input, and two supply-good flags from external comparators. All of these inputs pass through multi-flop synchronizers. From them the block decides when the two segments may be joined, and it drives the enables for the external connection switch, the rise-time boosters and the line precharge.

After power-up, after either supply flag drops, and after every enable cycle, the controller treats the backplane as if a transaction were already in flight. It joins the segments only after it sees a stop condition or a timed quiet period on the backplane, and only when both card lines read high. While the segments are joined, it computes the open-drain pull-down requests for each side of each line, so that each line behaves as one wired-AND net. It tracks which side started a low, which keeps its own drive from latching the line low.

Top module: `hsbus_link_ctrl`

## Requirements
- R1: While either supply flag (synchronized) is low, `link_o` and `boost_o` stay low. Bus activity seen during that lockout does not count toward qualification.
- R2: `prechg_o` is high while the controller is locked out or waiting to connect with enable high. It is low while enable is low and while linked.
- R3: Once out of lockout with enable high, a stop condition on the backplane qualifies the connection. A stop is a rising backplane SDA while backplane SCL stays high. With both card lines high, `link_o` rises on the (SYNC_STAGES+2)-th rising clock edge after the SDA rise, and not earlier.
- R4: With no stop seen, the connection qualifies only after both backplane lines have read high for IDLE_CYCLES consecutive clocks (default 4750, i.e. 95 µs at 50 MHz). Any low on either backplane line restarts that count.
- R5: The controller connects only while both card SDA and card SCL read high. If either is low after qualification, it keeps waiting. It links on the (SYNC_STAGES+1)-th edge after the last card line rises.
- R6: `link_o` and `boost_o` rise and fall together, in the same clock cycle.
- R7: While linked, a low on either side of a line drives the other side low through the matching `*_pull_o` output (1 = pull low). A line is released only when no device on either side holds it low. SDA and SCL are handled separately. No pull output is ever high while `link_o` is low.
- R8: Enable going low clears `link_o`, `boost_o` and `prechg_o` no later than the (SYNC_STAGES+1)-th rising edge. While enable is low, a low on one segment does not reach the other.
- R9: When enable returns high, the controller does not reconnect at once. It qualifies again (stop or idle, plus card lines high) before linking.
- R10: When the card or main supply flag drops, the controller unlinks within SYNC_STAGES+1 edges and returns to lockout. After the supply returns, it requalifies exactly as after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable (asynchronous, 1 = operate) |
| vmain_ok_i | input | 1 | Backplane supply above its lockout threshold |
| vcard_ok_i | input | 1 | Card supply above its lockout threshold |
| bp_sda_i | input | 1 | Backplane SDA level |
| bp_scl_i | input | 1 | Backplane SCL level |
| cd_sda_i | input | 1 | Card SDA level |
| cd_scl_i | input | 1 | Card SCL level |
| link_o | output | 1 | Join backplane and card segments |
| boost_o | output | 1 | Rise-time accelerator enable |
| prechg_o | output | 1 | Line precharge enable |
| bp_sda_pull_o | output | 1 | Pull backplane SDA low |
| bp_scl_pull_o | output | 1 | Pull backplane SCL low |
| cd_sda_pull_o | output | 1 | Pull card SDA low |
| cd_scl_pull_o | output | 1 | Pull card SCL low |

## Verification
The assertions assume that every input holds its level across at least one sampling edge, so each change reaches the synchronizer outputs as a clean step. They also assume that line levels fed back from the pull outputs return within one clock, as an open-drain net with pull-ups does. The bench keeps to this by changing inputs only on the falling clock edge. It models each bus line as the wired-AND of a device drive and the block's pull output, and it holds every random device change for several clocks before the next one. This leaves time for the ownership hand-over between sides to settle before the next change.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

    // Controller phases
    typedef enum logic [1:0] {
        ST_LOCK = 2'd0,   // supply lockout
        ST_OFF  = 2'd1,   // enable low
        ST_WAIT = 2'd2,   // waiting for stop/idle and card-high
        ST_LINK = 2'd3    // segments joined
    } link_state_e;

    // Per-line ownership of a low level
    typedef enum logic [1:0] {
        LN_FREE    = 2'd0,
        LN_BP_HELD = 2'd1,   // backplane side started the low, card side follows
        LN_CD_HELD = 2'd2,   // card side started the low, backplane follows
        LN_SETTLE  = 2'd3    // blind window while our release propagates
    } line_state_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } wire_pair_t;

    typedef struct packed {
        logic       en;
        logic       vmain;
        logic       vcard;
        wire_pair_t bp;
        wire_pair_t cd;
    } sample_t;

    // Stop: SDA low->high while SCL high in both samples
    function automatic logic stop_edge(input logic sda_prev, input logic sda_now,
                                       input logic scl_prev, input logic scl_now);
        return !sda_prev && sda_now && scl_prev && scl_now;
    endfunction

endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hsbus_qualify.sv
module hsbus_qualify
    import hsbus_pkg::*;
#(
    parameter int IDLE_CYCLES = 4750
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    output logic qual_o
);

    localparam int CW = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic [CW-1:0] quiet_cnt_q;
    logic          sda_d_q, scl_d_q;
    logic          qual_q;
    logic          bus_high;

    assign bus_high = bp_sda_i && bp_scl_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_d_q <= 1'b0;
            scl_d_q <= 1'b0;
        end else begin
            sda_d_q <= bp_sda_i;
            scl_d_q <= bp_scl_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !arm_i) begin
            quiet_cnt_q <= '0;
            qual_q      <= 1'b0;
        end else if (!bus_high) begin
            quiet_cnt_q <= '0;
            qual_q      <= 1'b0;
        end else begin
            if (quiet_cnt_q == LAST) begin
                qual_q <= 1'b1;
            end else begin
                quiet_cnt_q <= quiet_cnt_q + 1'b1;
            end
            if (stop_edge(sda_d_q, bp_sda_i, scl_d_q, bp_scl_i)) begin
                qual_q <= 1'b1;
            end
        end
    end

    assign qual_o = qual_q;

endmodule

// File: rtl/hsbus_line.sv
module hsbus_line
    import hsbus_pkg::*;
#(
    parameter int SETTLE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic bp_i,
    input  logic cd_i,
    output logic bp_pull_o,
    output logic cd_pull_o
);

    localparam int SW = $clog2(SETTLE_CYCLES + 1);

    line_state_e   st_q;
    logic [SW-1:0] settle_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            st_q     <= LN_FREE;
            settle_q <= '0;
        end else begin
            case (st_q)
                LN_FREE: begin
                    if (!bp_i) begin
                        st_q <= LN_BP_HELD;
                    end else if (!cd_i) begin
                        st_q <= LN_CD_HELD;
                    end
                end
                LN_BP_HELD: begin
                    if (bp_i) begin
                        st_q     <= LN_SETTLE;
                        settle_q <= '0;
                    end
                end
                LN_CD_HELD: begin
                    if (cd_i) begin
                        st_q     <= LN_SETTLE;
                        settle_q <= '0;
                    end
                end
                LN_SETTLE: begin
                    if (settle_q == SW'(SETTLE_CYCLES - 1)) begin
                        st_q <= LN_FREE;
                    end else begin
                        settle_q <= settle_q + 1'b1;
                    end
                end
                default: st_q <= LN_FREE;
            endcase
        end
    end

    assign cd_pull_o = (st_q == LN_BP_HELD);
    assign bp_pull_o = (st_q == LN_CD_HELD);

endmodule

// File: rtl/hsbus_fsm.sv
module hsbus_fsm
    import hsbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        supply_ok_i,
    input  logic        en_i,
    input  logic        qual_i,
    input  logic        card_free_i,
    output link_state_e next_o,
    output logic        arm_o,
    output logic        link_o,
    output logic        boost_o,
    output logic        prechg_o
);

    link_state_e st_q, st_d;
    logic        link_q, boost_q, prechg_q;

    always_comb begin
        st_d = st_q;
        if (!supply_ok_i) begin
            st_d = ST_LOCK;
        end else if (!en_i) begin
            st_d = ST_OFF;
        end else begin
            case (st_q)
                ST_LOCK, ST_OFF: st_d = ST_WAIT;
                ST_WAIT:         if (qual_i && card_free_i) st_d = ST_LINK;
                ST_LINK:         st_d = ST_LINK;
                default:         st_d = ST_LOCK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_LOCK;
            link_q   <= 1'b0;
            boost_q  <= 1'b0;
            prechg_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            link_q   <= (st_d == ST_LINK);
            boost_q  <= (st_d == ST_LINK);
            prechg_q <= en_i && ((st_d == ST_LOCK) || (st_d == ST_WAIT));
        end
    end

    assign next_o   = st_d;
    assign arm_o    = (st_q == ST_WAIT);
    assign link_o   = link_q;
    assign boost_o  = boost_q;
    assign prechg_o = prechg_q;

endmodule

// File: rtl/hsbus_link_ctrl.sv
module hsbus_link_ctrl
    import hsbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CYCLES = 4750
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic vmain_ok_i,
    input  logic vcard_ok_i,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    input  logic cd_sda_i,
    input  logic cd_scl_i,
    output logic link_o,
    output logic boost_o,
    output logic prechg_o,
    output logic bp_sda_pull_o,
    output logic bp_scl_pull_o,
    output logic cd_sda_pull_o,
    output logic cd_scl_pull_o
);

    localparam int SW     = $bits(sample_t);
    localparam int SETTLE = SYNC_STAGES + 1;
    localparam int NLINES = 2;   // index 0 = SDA, 1 = SCL

    sample_t     raw_s, syn_s;
    logic        en_s, vmain_s, vcard_s;
    logic        bp_sda_s, bp_scl_s, cd_sda_s, cd_scl_s;
    logic        qual, arm;
    link_state_e next_st;
    logic        line_active;

    logic [NLINES-1:0] bp_lvl, cd_lvl, bp_pull, cd_pull;

    always_comb begin
        raw_s.en     = en_i;
        raw_s.vmain  = vmain_ok_i;
        raw_s.vcard  = vcard_ok_i;
        raw_s.bp.sda = bp_sda_i;
        raw_s.bp.scl = bp_scl_i;
        raw_s.cd.sda = cd_sda_i;
        raw_s.cd.scl = cd_scl_i;
    end

    hsbus_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_s),
        .q_o (syn_s)
    );

    assign en_s     = syn_s.en;
    assign vmain_s  = syn_s.vmain;
    assign vcard_s  = syn_s.vcard;
    assign bp_sda_s = syn_s.bp.sda;
    assign bp_scl_s = syn_s.bp.scl;
    assign cd_sda_s = syn_s.cd.sda;
    assign cd_scl_s = syn_s.cd.scl;

    hsbus_qualify #(.IDLE_CYCLES(IDLE_CYCLES)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .arm_i    (arm),
        .bp_sda_i (bp_sda_s),
        .bp_scl_i (bp_scl_s),
        .qual_o   (qual)
    );

    hsbus_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .supply_ok_i (vmain_s && vcard_s),
        .en_i        (en_s),
        .qual_i      (qual),
        .card_free_i (cd_sda_s && cd_scl_s),
        .next_o      (next_st),
        .arm_o       (arm),
        .link_o      (link_o),
        .boost_o     (boost_o),
        .prechg_o    (prechg_o)
    );

    assign line_active = (next_st == ST_LINK);
    assign bp_lvl      = {bp_scl_s, bp_sda_s};
    assign cd_lvl      = {cd_scl_s, cd_sda_s};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            hsbus_line #(.SETTLE_CYCLES(SETTLE)) u_line (
                .clk       (clk),
                .rst       (rst),
                .active_i  (line_active),
                .bp_i      (bp_lvl[g]),
                .cd_i      (cd_lvl[g]),
                .bp_pull_o (bp_pull[g]),
                .cd_pull_o (cd_pull[g])
            );
        end
    endgenerate

    assign bp_sda_pull_o = bp_pull[0];
    assign bp_scl_pull_o = bp_pull[1];
    assign cd_sda_pull_o = cd_pull[0];
    assign cd_scl_pull_o = cd_pull[1];

endmodule

// File: rtl/hsbus_link_ctrl_chk.sv
module hsbus_link_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic en_s,
    input logic vmain_s,
    input logic vcard_s,
    input logic bp_sda_s,
    input logic bp_scl_s,
    input logic cd_sda_s,
    input logic cd_scl_s,
    input logic qual,
    input logic link_o,
    input logic boost_o,
    input logic prechg_o,
    input logic bp_sda_pull_o,
    input logic bp_scl_pull_o,
    input logic cd_sda_pull_o,
    input logic cd_scl_pull_o
);

    a_r1_lockout_unlinks: assert property (@(posedge clk) disable iff (rst)
        !(vmain_s && vcard_s) |=> !link_o);

    a_r10_card_supply_drop: assert property (@(posedge clk) disable iff (rst)
        !vcard_s |=> (!link_o && (prechg_o == $past(en_s))));

    a_r2_no_prechg_when_linked: assert property (@(posedge clk) disable iff (rst)
        link_o |-> !prechg_o);

    a_r5_card_high_before_link: assert property (@(posedge clk) disable iff (rst)
        $rose(link_o) |-> $past(cd_sda_s && cd_scl_s));

    a_r9_link_needs_qual: assert property (@(posedge clk) disable iff (rst)
        $rose(link_o) |-> $past(qual));

    a_r6_boost_tracks_link: assert property (@(posedge clk) disable iff (rst)
        link_o == boost_o);

    a_r8_enable_low_unlinks: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> (!link_o && !prechg_o));

    a_r7_pull_needs_link: assert property (@(posedge clk) disable iff (rst)
        (bp_sda_pull_o || bp_scl_pull_o || cd_sda_pull_o || cd_scl_pull_o) |-> link_o);

    a_r7_sda_one_side: assert property (@(posedge clk) disable iff (rst)
        !(bp_sda_pull_o && cd_sda_pull_o));

    a_r7_scl_one_side: assert property (@(posedge clk) disable iff (rst)
        !(bp_scl_pull_o && cd_scl_pull_o));

    a_r7_card_sda_follows: assert property (@(posedge clk) disable iff (rst)
        cd_sda_pull_o |-> $past(!bp_sda_s));

    a_r7_bp_sda_follows: assert property (@(posedge clk) disable iff (rst)
        bp_sda_pull_o |-> $past(!cd_sda_s));

    a_r7_card_scl_follows: assert property (@(posedge clk) disable iff (rst)
        cd_scl_pull_o |-> $past(!bp_scl_s));

    a_r7_bp_scl_follows: assert property (@(posedge clk) disable iff (rst)
        bp_scl_pull_o |-> $past(!cd_scl_s));

endmodule

bind hsbus_link_ctrl hsbus_link_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .en_s          (en_s),
    .vmain_s       (vmain_s),
    .vcard_s       (vcard_s),
    .bp_sda_s      (bp_sda_s),
    .bp_scl_s      (bp_scl_s),
    .cd_sda_s      (cd_sda_s),
    .cd_scl_s      (cd_scl_s),
    .qual          (qual),
    .link_o        (link_o),
    .boost_o       (boost_o),
    .prechg_o      (prechg_o),
    .bp_sda_pull_o (bp_sda_pull_o),
    .bp_scl_pull_o (bp_scl_pull_o),
    .cd_sda_pull_o (cd_sda_pull_o),
    .cd_scl_pull_o (cd_scl_pull_o)
);

// File: tb/hsbus_link_ctrl_tb.sv
`timescale 1ns/1ps
module hsbus_link_ctrl_tb;

    localparam int SYNC = 2;
    localparam int IDLE = 4750;
    localparam int SETTLE_WAIT = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1;
    logic vmain = 1'b0;
    logic vcard = 1'b0;
    logic [3:0] dev = 4'b0;   // 1 = device pulls low: {cd_scl, cd_sda, bp_scl, bp_sda}

    logic link, boost, prechg;
    logic bp_sda_pull, bp_scl_pull, cd_sda_pull, cd_scl_pull;
    logic bp_sda_w, bp_scl_w, cd_sda_w, cd_scl_w;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // open-drain nets with pull-ups
    assign bp_sda_w = ~(dev[0] | bp_sda_pull);
    assign bp_scl_w = ~(dev[1] | bp_scl_pull);
    assign cd_sda_w = ~(dev[2] | cd_sda_pull);
    assign cd_scl_w = ~(dev[3] | cd_scl_pull);

    hsbus_link_ctrl #(.SYNC_STAGES(SYNC), .IDLE_CYCLES(IDLE)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .en_i          (en),
        .vmain_ok_i    (vmain),
        .vcard_ok_i    (vcard),
        .bp_sda_i      (bp_sda_w),
        .bp_scl_i      (bp_scl_w),
        .cd_sda_i      (cd_sda_w),
        .cd_scl_i      (cd_scl_w),
        .link_o        (link),
        .boost_o       (boost),
        .prechg_o      (prechg),
        .bp_sda_pull_o (bp_sda_pull),
        .bp_scl_pull_o (bp_scl_pull),
        .cd_sda_pull_o (cd_sda_pull),
        .cd_scl_pull_o (cd_scl_pull)
    );

    function automatic logic wired(input logic a_low, input logic b_low);
        return ~(a_low | b_low);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_lines(input string req);
        chk(req, {31'd0, bp_sda_w}, {31'd0, wired(dev[0], dev[2])});
        chk(req, {31'd0, cd_sda_w}, {31'd0, wired(dev[0], dev[2])});
        chk(req, {31'd0, bp_scl_w}, {31'd0, wired(dev[1], dev[3])});
        chk(req, {31'd0, cd_scl_w}, {31'd0, wired(dev[1], dev[3])});
    endtask

    // start then stop on the backplane with SCL held high; leaves caller at the SDA rise
    task automatic bp_start_stop();
        dev[0] = 1'b1;
        tick(6);
        dev[0] = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));

        // reset state
        tick(5);
        chk("R1 reset link", {31'd0, link}, 32'd0);
        chk("R6 reset boost", {31'd0, boost}, 32'd0);
        chk("R7 reset pulls", {28'd0, bp_sda_pull, bp_scl_pull, cd_sda_pull, cd_scl_pull}, 32'd0);
        rst = 1'b0;
        tick(5);
        chk("R2 precharge in lockout", {31'd0, prechg}, 32'd1);
        chk("R1 no link in lockout", {31'd0, link}, 32'd0);

        // activity during lockout must not qualify
        bp_start_stop();
        tick(10);
        chk("R1 stop ignored in lockout", {31'd0, link}, 32'd0);

        // supplies up, quiet bus: idle path
        vmain = 1'b1;
        vcard = 1'b1;
        tick(IDLE + 3);
        chk("R4 not linked before idle time", {31'd0, link}, 32'd0);
        chk("R2 precharge while waiting", {31'd0, prechg}, 32'd1);
        tick(1);
        chk("R4 linked after idle time", {31'd0, link}, 32'd1);
        chk("R6 boost with link", {31'd0, boost}, 32'd1);
        chk("R2 no precharge when linked", {31'd0, prechg}, 32'd0);

        // directed wired-AND: card SDA low only
        dev = 4'b0100;
        tick(SETTLE_WAIT);
        check_lines("R7 card sda low reaches backplane");
        dev = 4'b0001;
        tick(SETTLE_WAIT);
        check_lines("R7 backplane sda low reaches card");
        dev = 4'b0000;
        tick(SETTLE_WAIT);
        check_lines("R7 all released");

        // random wired-AND traffic while linked
        for (int i = 0; i < 60; i++) begin
            int pick = $urandom_range(3, 0);
            dev[pick] = ~dev[pick];
            tick(SETTLE_WAIT);
            check_lines("R7 random wired-and");
            chk("R7 stays linked", {31'd0, link}, 32'd1);
        end
        dev = 4'b0000;
        tick(SETTLE_WAIT);
        check_lines("R7 released after random");

        // enable cycle
        en = 1'b0;
        tick(SYNC + 1);
        chk("R8 link drops on enable low", {31'd0, link}, 32'd0);
        chk("R8 boost drops on enable low", {31'd0, boost}, 32'd0);
        chk("R8 precharge off on enable low", {31'd0, prechg}, 32'd0);
        dev = 4'b0001;
        tick(SETTLE_WAIT);
        chk("R8 isolated while disabled", {31'd0, cd_sda_w}, 32'd1);
        dev = 4'b0000;
        en = 1'b1;
        tick(10);
        chk("R9 no immediate reconnect", {31'd0, link}, 32'd0);
        chk("R2 precharge back on", {31'd0, prechg}, 32'd1);
        bp_start_stop();
        tick(SYNC + 1);
        chk("R3 not linked before stop latency", {31'd0, link}, 32'd0);
        tick(1);
        chk("R3 linked after stop", {31'd0, link}, 32'd1);
        chk("R9 requalified by stop", {31'd0, boost}, 32'd1);

        // card supply drop, then card line held low
        vcard = 1'b0;
        tick(SYNC + 1);
        chk("R10 card supply drop unlinks", {31'd0, link}, 32'd0);
        chk("R10 precharge in lockout", {31'd0, prechg}, 32'd1);
        dev = 4'b0100;
        tick(4);
        vcard = 1'b1;
        tick(IDLE + 20);
        chk("R5 waits for card sda high", {31'd0, link}, 32'd0);
        dev = 4'b0000;
        tick(SYNC);
        chk("R5 not yet linked", {31'd0, link}, 32'd0);
        tick(1);
        chk("R5 linked once card high", {31'd0, link}, 32'd1);

        // main supply drop, requalify by stop
        vmain = 1'b0;
        tick(SYNC + 1);
        chk("R10 main supply drop unlinks", {31'd0, link}, 32'd0);
        vmain = 1'b1;
        tick(20);
        chk("R10 no reconnect without qualification", {31'd0, link}, 32'd0);
        bp_start_stop();
        tick(SYNC + 2);
        chk("R10 relinked after stop", {31'd0, link}, 32'd1);

        // lockout with enable low: no precharge
        en = 1'b0;
        vcard = 1'b0;
        tick(SYNC + 2);
        chk("R2 precharge off with enable low in lockout", {31'd0, prechg}, 32'd0);
        chk("R1 unlinked in lockout", {31'd0, link}, 32'd0);

        finish_run();
    end

endmodule